// File: doc/BRIEF.md
# Dual-Channel Wiper Register and Instruction Engine

This block is the register core behind a two-channel digital potentiometer. Each channel keeps one volatile wiper code, which is a top-level output that selects a tap of the resistor chain. Each channel also has a bank of four storage words that stand in for nonvolatile memory. A bus front end decodes the serial protocol. It hands this engine the instruction byte, the optional data byte, step pulses and the STOP event. In return it receives a registered response pulse with an accept flag and, for reads, the read data.

Instructions read or write a wiper or a storage word, copy between a storage word and its wiper on one channel or on both channels at once, or arm a step mode in which pulses move one wiper up or down by one code. Any copy into storage is held pending until STOP. At STOP it is committed only if write-protect is high, and then a busy interval of a parameterised number of clocks stands in for the programming time. While busy is high, the front end withholds its address acknowledge and the engine refuses every instruction. A reset acts as power-up: each wiper is reloaded from storage word 0 of its channel, and the storage keeps its contents.

Top module: `wiper_bank_engine`

## Requirements
- R1: The instruction byte carries the opcode in bits [7:4], the storage index in bits [3:2] and the channel in bits [1:0]. Opcode 1001 (read wiper) answers one cycle later with resp_vld=1, resp_ack=1 and rd_data equal to the selected wiper code.
- R2: Opcode 1010 (write wiper), followed by a data byte, loads that byte into the wiper on the edge that answers the data byte with an acknowledge. Write-protect does not affect this.
- R3: Opcode 1011 (read storage) answers with the storage word at [channel][index]. rd_data keeps its value across responses that are not reads.
- R4: Opcode 1100 (write storage) acknowledges its data byte when wp_n=1. The word is written on the STOP edge, and busy is then high for exactly PROG_CYCLES cycles.
- R5: With wp_n=0 when the data byte of opcode 1100 arrives, resp_ack=0 and the storage word is unchanged. The following STOP raises no busy.
- R6: If wp_n falls after the data byte but before STOP, the write is dropped and busy stays low. If wp_n falls while busy is high, the write has already taken effect.
- R7: Opcode 1101 copies storage [channel][index] into the wiper on the instruction edge. Opcode 1110 captures the wiper and commits it to storage [channel][index] at STOP, followed by a busy interval.
- R8: Gang opcodes 0001 (storage to wipers) and 1000 (wipers to storage) act on both channels with the same index. They are accepted only when the channel field is 00.
- R9: After opcode 0010 is accepted, each step pulse moves the selected wiper by one code: up when step_up=1, down otherwise. The code saturates at 0 and at the maximum. Step mode ends at STOP or at the next instruction.
- R10: An opcode outside the table, or a channel field that names a channel that does not exist, gets resp_ack=0 and changes no register.
- R11: While busy is high, every instruction gets resp_ack=0, and no wiper or storage word changes.
- R12: On reset, each wiper takes the value of storage word 0 of its channel, busy and resp_vld go low, and the storage keeps its contents. Storage starts at INIT_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, acts as power-up |
| wp_n | input | 1 | Write-protect, low blocks storage programming |
| inst_vld | input | 1 | Instruction byte strobe |
| inst_byte | input | 8 | Instruction byte: opcode, index, channel |
| wdat_vld | input | 1 | Data byte strobe |
| wdat_byte | input | DW | Data byte |
| step_vld | input | 1 | Step pulse in step mode |
| step_up | input | 1 | Step direction, 1 = up |
| stop_evt | input | 1 | Bus STOP seen |
| resp_vld | output | 1 | Response pulse for an instruction or data byte |
| resp_ack | output | 1 | Accept flag, valid with resp_vld |
| rd_data | output | DW | Read data |
| busy | output | 1 | Programming interval in progress |
| wiper_codes | output | NUM_CH*DW | Wiper codes, channel 0 in the low bits |

## Verification
The assertions take it as given that the front end presents at most one of inst_vld, wdat_vld, step_vld and stop_evt in any cycle, and that a data byte arrives only after an instruction. The stimulus drives these strobes one at a time, with one or more idle cycles between them, in the order a bus transaction produces. The busy-length checks assume PROG_CYCLES of at least 2. The bench overrides the default with a short interval so that many programming cycles fit in one run.

// File: rtl/wbe_pkg.sv
package wbe_pkg;
  localparam logic [3:0] OP_RD_WIP  = 4'b1001;
  localparam logic [3:0] OP_WR_WIP  = 4'b1010;
  localparam logic [3:0] OP_RD_ST   = 4'b1011;
  localparam logic [3:0] OP_WR_ST   = 4'b1100;
  localparam logic [3:0] OP_ST2W    = 4'b1101;
  localparam logic [3:0] OP_W2ST    = 4'b1110;
  localparam logic [3:0] OP_G_ST2W  = 4'b0001;
  localparam logic [3:0] OP_G_W2ST  = 4'b1000;
  localparam logic [3:0] OP_STEP    = 4'b0010;

  localparam int IDX_W = 2;
  localparam int SEL_W = 2;
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {
    M_IDLE,
    M_WWIP,
    M_WST,
    M_STEP
  } mode_t;

  typedef struct packed {
    logic [3:0]       op;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] pot;
    logic             legal;
  } dec_t;
endpackage

// File: rtl/wbe_decode.sv
module wbe_decode
  import wbe_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [7:0] inst_byte,
  output dec_t       dec
);
  localparam logic [SEL_W:0] NCH = (SEL_W+1)'(NUM_CH);

  logic pot_ok;

  always_comb begin
    dec.op    = inst_byte[7:4];
    dec.idx   = inst_byte[3:2];
    dec.pot   = inst_byte[1:0];
    pot_ok    = ({1'b0, inst_byte[1:0]} < NCH);
    unique case (inst_byte[7:4])
      OP_RD_WIP, OP_WR_WIP, OP_RD_ST, OP_WR_ST,
      OP_ST2W, OP_W2ST, OP_STEP:  dec.legal = pot_ok;
      OP_G_ST2W, OP_G_W2ST:       dec.legal = (inst_byte[1:0] == '0);
      default:                    dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/wbe_channel.sv
module wbe_channel
  import wbe_pkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] INIT_CODE = 8'h80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [DW-1:0]    ld_val,
  input  logic             st_we,
  input  logic [IDX_W-1:0] st_idx,
  input  logic [DW-1:0]    st_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             step_en,
  input  logic             step_up,
  output logic [DW-1:0]    wiper,
  output logic [DW-1:0]    rd_word
);
  localparam logic [DW-1:0] CODE_MAX = '1;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT_CODE;
  end

  always_ff @(posedge clk) begin
    if (st_we) mem[st_idx] <= st_wdata;
  end

  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper <= mem[0];
    end else if (ld_en) begin
      wiper <= ld_val;
    end else if (step_en) begin
      if (step_up) begin
        if (wiper != CODE_MAX) wiper <= wiper + 1'b1;
      end else begin
        if (wiper != '0) wiper <= wiper - 1'b1;
      end
    end
  end

  // R9
  step_top_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !ld_en && step_up && wiper == CODE_MAX) |=> (wiper == CODE_MAX));

  // R9
  step_bot_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !ld_en && !step_up && wiper == '0) |=> (wiper == '0));

  // R9
  step_move_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !ld_en && step_up && wiper != CODE_MAX) |=> (wiper == $past(wiper) + 1'b1));
endmodule

// File: rtl/wbe_prog_timer.sv
module wbe_prog_timer #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  generate
    if (CYCLES > 1) begin : g_len
      // R4
      busy_min_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);
    end
  endgenerate
endmodule

// File: rtl/wiper_bank_engine.sv
module wiper_bank_engine
  import wbe_pkg::*;
#(
  parameter int            DW          = 8,
  parameter int            NUM_CH      = 2,
  parameter int            PROG_CYCLES = 1000000,
  parameter logic [DW-1:0] INIT_CODE   = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wp_n,
  input  logic                 inst_vld,
  input  logic [7:0]           inst_byte,
  input  logic                 wdat_vld,
  input  logic [DW-1:0]        wdat_byte,
  input  logic                 step_vld,
  input  logic                 step_up,
  input  logic                 stop_evt,
  output logic                 resp_vld,
  output logic                 resp_ack,
  output logic [DW-1:0]        rd_data,
  output logic                 busy,
  output logic [NUM_CH*DW-1:0] wiper_codes
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  dec_t dec;
  wbe_decode #(.NUM_CH(NUM_CH)) u_dec (.inst_byte(inst_byte), .dec(dec));

  mode_t            mode_q;
  logic [CH_W-1:0]  sel_ch_q;
  logic [IDX_W-1:0] sel_idx_q;
  logic [NUM_CH-1:0] pend_mask_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [DW-1:0]    pend_data_q [NUM_CH];

  logic [DW-1:0] wip   [NUM_CH];
  logic [DW-1:0] rdw   [NUM_CH];
  logic          ld_en [NUM_CH];
  logic [DW-1:0] ld_val[NUM_CH];
  logic          st_we [NUM_CH];
  logic          step_en[NUM_CH];

  logic            accept_inst;
  logic            prog_start;
  logic [CH_W-1:0] pot_ix;

  assign pot_ix      = dec.pot[CH_W-1:0];
  assign accept_inst = inst_vld && !busy && dec.legal;
  assign prog_start  = stop_evt && !busy && wp_n && (|pend_mask_q);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ld_en[c]   = 1'b0;
      ld_val[c]  = rdw[c];
      if (accept_inst &&
          ((dec.op == OP_ST2W && dec.pot == SEL_W'(c)) || dec.op == OP_G_ST2W)) begin
        ld_en[c] = 1'b1;
      end
      if (wdat_vld && mode_q == M_WWIP && sel_ch_q == CH_W'(c)) begin
        ld_en[c]  = 1'b1;
        ld_val[c] = wdat_byte;
      end
      step_en[c] = step_vld && mode_q == M_STEP && sel_ch_q == CH_W'(c);
      st_we[c]   = prog_start && pend_mask_q[c];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      wbe_channel #(.DW(DW), .INIT_CODE(INIT_CODE)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en[g]),
        .ld_val  (ld_val[g]),
        .st_we   (st_we[g]),
        .st_idx  (pend_idx_q),
        .st_wdata(pend_data_q[g]),
        .rd_idx  (dec.idx),
        .step_en (step_en[g]),
        .step_up (step_up),
        .wiper   (wip[g]),
        .rd_word (rdw[g])
      );
      assign wiper_codes[g*DW +: DW] = wip[g];
    end
  endgenerate

  wbe_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(prog_start),
    .busy (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_IDLE;
      sel_ch_q    <= '0;
      sel_idx_q   <= '0;
      pend_mask_q <= '0;
      pend_idx_q  <= '0;
      resp_vld    <= 1'b0;
      resp_ack    <= 1'b0;
      rd_data     <= '0;
      for (int c = 0; c < NUM_CH; c++) pend_data_q[c] <= '0;
    end else begin
      resp_vld <= 1'b0;
      resp_ack <= 1'b0;
      if (inst_vld) begin
        resp_vld    <= 1'b1;
        resp_ack    <= accept_inst;
        mode_q      <= M_IDLE;
        pend_mask_q <= '0;
        if (accept_inst) begin
          unique case (dec.op)
            OP_RD_WIP: rd_data <= wip[pot_ix];
            OP_RD_ST:  rd_data <= rdw[pot_ix];
            OP_WR_WIP: begin
              mode_q   <= M_WWIP;
              sel_ch_q <= pot_ix;
            end
            OP_WR_ST: begin
              mode_q    <= M_WST;
              sel_ch_q  <= pot_ix;
              sel_idx_q <= dec.idx;
            end
            OP_STEP: begin
              mode_q   <= M_STEP;
              sel_ch_q <= pot_ix;
            end
            OP_W2ST, OP_G_W2ST: begin
              pend_idx_q <= dec.idx;
              for (int c = 0; c < NUM_CH; c++) begin
                pend_data_q[c] <= wip[c];
                pend_mask_q[c] <= (dec.op == OP_G_W2ST) || (dec.pot == SEL_W'(c));
              end
            end
            default: ;
          endcase
        end
      end else if (wdat_vld) begin
        resp_vld <= 1'b1;
        mode_q   <= M_IDLE;
        if (mode_q == M_WWIP) begin
          resp_ack <= 1'b1;
        end else if (mode_q == M_WST && wp_n) begin
          resp_ack              <= 1'b1;
          pend_idx_q            <= sel_idx_q;
          pend_data_q[sel_ch_q] <= wdat_byte;
          for (int c = 0; c < NUM_CH; c++)
            pend_mask_q[c] <= (sel_ch_q == CH_W'(c));
        end
      end else if (stop_evt) begin
        mode_q      <= M_IDLE;
        pend_mask_q <= '0;
      end
    end
  end

  // R11
  busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (inst_vld && busy) |=> (resp_vld && !resp_ack));

  // R10
  illegal_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (inst_vld && !dec.legal) |=> (resp_vld && !resp_ack));

  // R5
  wp_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (wdat_vld && !wp_n && mode_q == M_WST) |=> !resp_ack);

  // R6
  commit_guard_chk: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> (wp_n && stop_evt));

  // R4
  busy_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> busy);
endmodule

// File: tb/wiper_bank_engine_tb.sv
`timescale 1ns/100ps
module wiper_bank_engine_tb_top;
  localparam int DW = 8;
  localparam int NCH = 2;
  localparam int PROG = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_n = 1'b1;
  logic inst_vld = 1'b0;
  logic [7:0] inst_byte = '0;
  logic wdat_vld = 1'b0;
  logic [7:0] wdat_byte = '0;
  logic step_vld = 1'b0;
  logic step_up = 1'b0;
  logic stop_evt = 1'b0;
  logic resp_vld, resp_ack, busy;
  logic [7:0] rd_data;
  logic [NCH*DW-1:0] wiper_codes;

  always #2.5 clk = ~clk;

  wiper_bank_engine #(.DW(DW), .NUM_CH(NCH), .PROG_CYCLES(PROG), .INIT_CODE(8'h80)) dut_i (
    .clk(clk), .rst(rst), .wp_n(wp_n), .inst_vld(inst_vld), .inst_byte(inst_byte),
    .wdat_vld(wdat_vld), .wdat_byte(wdat_byte), .step_vld(step_vld), .step_up(step_up),
    .stop_evt(stop_evt), .resp_vld(resp_vld), .resp_ack(resp_ack), .rd_data(rd_data),
    .busy(busy), .wiper_codes(wiper_codes));

  int checks = 0;
  int errors = 0;
  string cur_req = "R12";

  int m_wip[NCH];
  int m_st[NCH][4];
  bit m_busy = 0;
  int m_cnt = 0;
  int m_mode = 0;
  int m_ch = 0;
  int m_idx = 0;
  bit m_pm[NCH];
  int m_pidx = 0;
  int m_pd[NCH];
  bit m_rv = 0;
  bit m_ra = 0;
  int m_rd = 0;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_edge();
    bit ob;
    bit ok;
    int op, ix, pt;
    ob = m_busy;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin m_wip[c] = m_st[c][0]; m_pm[c] = 0; end
      m_busy = 0; m_cnt = 0; m_mode = 0; m_rv = 0; m_ra = 0; m_rd = 0;
      return;
    end
    if (stop_evt && !ob && wp_n && (m_pm[0] || m_pm[1])) begin
      for (int c = 0; c < NCH; c++) if (m_pm[c]) m_st[c][m_pidx] = m_pd[c];
      m_busy = 1; m_cnt = PROG - 1;
    end else if (ob) begin
      if (m_cnt == 0) m_busy = 0; else m_cnt--;
    end
    m_rv = 0; m_ra = 0;
    if (inst_vld) begin
      op = inst_byte[7:4]; ix = inst_byte[3:2]; pt = inst_byte[1:0];
      m_rv = 1; m_mode = 0;
      for (int c = 0; c < NCH; c++) m_pm[c] = 0;
      ok = 0;
      if (!ob) begin
        case (op)
          9:  if (pt < NCH) begin ok = 1; m_rd = m_wip[pt]; end
          10: if (pt < NCH) begin ok = 1; m_mode = 1; m_ch = pt; end
          11: if (pt < NCH) begin ok = 1; m_rd = m_st[pt][ix]; end
          12: if (pt < NCH) begin ok = 1; m_mode = 2; m_ch = pt; m_idx = ix; end
          13: if (pt < NCH) begin ok = 1; m_wip[pt] = m_st[pt][ix]; end
          14: if (pt < NCH) begin ok = 1; m_pm[pt] = 1; m_pidx = ix; m_pd[pt] = m_wip[pt]; end
          1:  if (pt == 0) begin ok = 1; for (int c = 0; c < NCH; c++) m_wip[c] = m_st[c][ix]; end
          8:  if (pt == 0) begin
                ok = 1; m_pidx = ix;
                for (int c = 0; c < NCH; c++) begin m_pm[c] = 1; m_pd[c] = m_wip[c]; end
              end
          2:  if (pt < NCH) begin ok = 1; m_mode = 3; m_ch = pt; end
          default: ok = 0;
        endcase
      end
      m_ra = ok;
    end else if (wdat_vld) begin
      m_rv = 1;
      if (m_mode == 1) begin m_wip[m_ch] = wdat_byte; m_ra = 1; end
      else if (m_mode == 2 && wp_n) begin
        m_ra = 1; m_pidx = m_idx; m_pd[m_ch] = wdat_byte;
        for (int c = 0; c < NCH; c++) m_pm[c] = (c == m_ch);
      end
      m_mode = 0;
    end else if (step_vld) begin
      if (m_mode == 3) begin
        if (step_up && m_wip[m_ch] < 255) m_wip[m_ch]++;
        if (!step_up && m_wip[m_ch] > 0) m_wip[m_ch]--;
      end
    end else if (stop_evt) begin
      m_mode = 0;
      for (int c = 0; c < NCH; c++) m_pm[c] = 0;
    end
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
    model_edge();
    for (int c = 0; c < NCH; c++)
      check(cur_req, int'(wiper_codes[c*DW +: DW]), m_wip[c], $sformatf("wiper%0d", c));
    check(cur_req, int'(busy), int'(m_busy), "busy");
    check(cur_req, int'(resp_vld), int'(m_rv), "resp_vld");
    check(cur_req, int'(resp_ack), int'(m_ra), "resp_ack");
    check(cur_req, int'(rd_data), m_rd, "rd_data");
    inst_vld = 0; wdat_vld = 0; step_vld = 0; stop_evt = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic inst(logic [7:0] b);
    inst_vld = 1; inst_byte = b; cyc(); cyc();
  endtask
  task automatic dat(logic [7:0] b);
    wdat_vld = 1; wdat_byte = b; cyc(); cyc();
  endtask
  task automatic stop();
    stop_evt = 1; cyc(); cyc();
  endtask
  task automatic step(bit up);
    step_vld = 1; step_up = up; cyc(); cyc();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_pm[c] = 0; m_pd[c] = 0; m_wip[c] = 0;
      for (int i = 0; i < 4; i++) m_st[c][i] = 8'h80;
    end
    cur_req = "R12";
    rst = 1; idle(3); rst = 0; idle(1);
    check("R12", int'(wiper_codes[7:0]), 8'h80, "reset wiper0");
    check("R12", int'(busy), 0, "reset busy");

    cur_req = "R1";
    inst(8'b1001_00_00);
    cur_req = "R2";
    wp_n = 0; inst(8'b1010_00_01); dat(8'h3C); stop(); wp_n = 1;
    check("R2", int'(wiper_codes[15:8]), 8'h3C, "wiper1 written");

    cur_req = "R4";
    inst(8'b1100_10_00); dat(8'hA5); stop(); idle(PROG + 2);
    cur_req = "R3";
    inst(8'b1011_10_00);
    check("R3", int'(rd_data), 8'hA5, "read stored word");
    inst(8'b1001_00_01);

    cur_req = "R5";
    wp_n = 0; inst(8'b1100_01_01); dat(8'h11); stop(); wp_n = 1;
    inst(8'b1011_01_01);
    check("R5", int'(rd_data), 8'h80, "protected word unchanged");

    cur_req = "R6";
    inst(8'b1100_11_01); dat(8'h5A); wp_n = 0; stop(); wp_n = 1; idle(2);
    inst(8'b1011_11_01);
    check("R6", int'(rd_data), 8'h80, "cancelled write");
    inst(8'b1100_11_01); dat(8'h5A); stop(); wp_n = 0; idle(PROG + 2); wp_n = 1;
    inst(8'b1011_11_01);
    check("R6", int'(rd_data), 8'h5A, "write survives late protect");

    cur_req = "R7";
    inst(8'b1101_10_00);
    check("R7", int'(wiper_codes[7:0]), 8'hA5, "store to wiper");
    inst(8'b1110_00_01); stop(); idle(PROG + 2);
    inst(8'b1011_00_01);

    cur_req = "R8";
    inst(8'b1000_01_00); stop(); idle(PROG + 2);
    inst(8'b1010_00_00); dat(8'h00); inst(8'b1010_00_01); dat(8'hFF);
    inst(8'b0001_01_01);
    inst(8'b0001_01_00);
    check("R8", int'(wiper_codes[15:8]), 8'h3C, "gang restore ch1");

    cur_req = "R9";
    inst(8'b0010_00_00); step(1); step(1); step(0); stop(); step(1);
    inst(8'b1010_00_00); dat(8'hFE);
    inst(8'b0010_00_00); step(1); step(1); step(1);
    check("R9", int'(wiper_codes[7:0]), 8'hFF, "saturate top");
    inst(8'b1010_00_00); dat(8'h01);
    inst(8'b0010_00_00); step(0); step(0); step(0); stop();
    check("R9", int'(wiper_codes[7:0]), 8'h00, "saturate bottom");

    cur_req = "R10";
    inst(8'h30); inst(8'hF0); inst(8'b1001_00_10); inst(8'b1010_00_11); dat(8'h77);
    inst(8'b1000_00_10); stop();

    cur_req = "R11";
    inst(8'b1100_00_00); dat(8'h42); inst(8'b1100_00_01); dat(8'h24);
    cur_req = "R4";
    inst(8'b1100_00_01); dat(8'h24); stop();
    cur_req = "R11";
    inst(8'b1001_00_00); inst(8'b1010_00_00); dat(8'h99); inst(8'b1101_00_00);
    check("R11", int'(wiper_codes[7:0]), 8'h00, "wiper held while busy");
    idle(PROG + 2);

    cur_req = "R12";
    inst(8'b1100_00_00); dat(8'h42); stop(); idle(PROG + 2);
    rst = 1; idle(2); rst = 0; idle(1);
    check("R12", int'(wiper_codes[7:0]), 8'h42, "recall ch0");
    check("R12", int'(wiper_codes[15:8]), 8'h24, "recall ch1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule